// File: doc/BRIEF.md
# Machine-mode CSR and trap unit

This block holds the machine-level control and status state of a 32-bit RISC-V hart together with its current privilege level. The execute stage presents one CSR request per cycle: an address, an operation (plain write, bit set or bit clear) and an operand. The block returns the old value and an illegal flag combinationally. Legal writes take effect at the next clock edge, after the block applies each register's write mask.

The block also takes the two control-flow events that touch this state. A trap entry saves the faulting PC and cause, stacks the interrupt enable and the privilege into the status register, raises the privilege to machine mode, and returns a handler address. That address is either the trap-vector base or, for interrupt causes in vectored mode, the base plus an offset taken from the cause. A trap return restores the privilege and the interrupt enable, and returns the saved PC. A free-running counter advances every clock and can be read at two addresses.

Top module: `mcsr_unit`

## Requirements
- R1: `csr_illegal` is 1 when the address is not in the map of R2, when address bits 9:8 exceed the current privilege, or when `csr_op` is 3. An illegal request changes no register.
- R2: The map is 0x300 status, 0x304 enable, 0x305 vector base, 0x340 scratch, 0x341 saved PC, 0x342 cause, 0xB00/0xB02 counter, 0x301 ISA, 0xF11–0xF14 ID registers, 0x343 trap value and 0x344 pending. The ISA register reads 0x40101105. The ID, trap-value and pending registers read 0. Writes to any of these read-only registers are legal and ignored.
- R3: A write to the vector base forces bit 1 to 0. A write to the saved PC forces bit 0 to 0. A write to the cause keeps only bit 31 and bits 7:0.
- R4: The counter increases by one on every clock. A legal write to 0xB00 or 0xB02 loads it instead, and both addresses read the same storage.
- R5: A trap entry sets the privilege to 3, copies the old privilege into status bits 12:11, sets status bit 7 when status bit 3 was 1, clears bit 3, and loads the cause and the saved PC from `trap_cause` and `trap_epc` unmasked.
- R6: `trap_target` is the vector base with bit 0 cleared. When base bit 0 and cause bit 31 are both 1, four times the cause code is added.
- R7: A trap return loads the privilege from status bits 12:11, sets bit 3 when bit 7 was 1, and clears bit 7. `mret_pc` always shows the saved PC.
- R8: After reset the privilege is 3 and every writable register reads 0.
- R9: `csr_op` 0 writes the operand, 1 ORs it into the old value and 2 clears the operand's bits. The R3 masks are applied to the combined result.
- R10: A trap entry in the same cycle as a CSR write wins: the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR write request valid |
| csr_op | input | 2 | 0 write, 1 set, 2 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Operand |
| csr_rdata | output | 32 | Current value at csr_addr |
| csr_illegal | output | 1 | Access not permitted |
| trap_take | input | 1 | Enter a trap this cycle |
| trap_cause | input | 32 | Cause, bit 31 marks an interrupt |
| trap_epc | input | 32 | PC to save |
| trap_target | output | 32 | Handler address |
| mret_take | input | 1 | Return from trap this cycle |
| mret_pc | output | 32 | Saved PC to return to |
| priv | output | 2 | Current privilege level |

## Verification
A trap entry and a CSR write can land in the same cycle. The bench provokes this by asserting `trap_take` on the clock where a write to the saved PC, and in a second case to the scratch register, is presented. It then reads both registers back and expects the trap's PC and the old scratch value. The bench also checks that an access made from user level leaves state alone once the privilege has dropped through a trap return.

// File: rtl/mcsr_unit.sv
module mcsr_unit #(
  parameter logic [31:0] ISA_WORD = 32'h4010_1105
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_req,
  input  logic [1:0]  csr_op,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  input  logic        trap_take,
  input  logic [31:0] trap_cause,
  input  logic [31:0] trap_epc,
  output logic [31:0] trap_target,
  input  logic        mret_take,
  output logic [31:0] mret_pc,
  output logic [1:0]  priv
);
  localparam logic [1:0] PRIV_M = 2'd3;

  logic [1:0]  priv_q;
  logic [31:0] mstatus_q, mie_q, mtvec_q, mscratch_q, mepc_q, mcause_q, cycle_q;
  logic        hit;
  logic [31:0] combined;
  logic        wr_en;

  always_comb begin
    hit = 1'b1;
    csr_rdata = 32'h0;
    case (csr_addr)
      12'h300: csr_rdata = mstatus_q;
      12'h301: csr_rdata = ISA_WORD;
      12'h304: csr_rdata = mie_q;
      12'h305: csr_rdata = mtvec_q;
      12'h340: csr_rdata = mscratch_q;
      12'h341: csr_rdata = mepc_q;
      12'h342: csr_rdata = mcause_q;
      12'h343, 12'h344: csr_rdata = 32'h0;
      12'hF11, 12'hF12, 12'hF13, 12'hF14: csr_rdata = 32'h0;
      12'hB00, 12'hB02: csr_rdata = cycle_q;
      default: hit = 1'b0;
    endcase
  end

  assign csr_illegal = !hit || (csr_addr[9:8] > priv_q) || (csr_op == 2'd3);

  assign combined = (csr_op == 2'd1) ? (csr_rdata | csr_wdata) :
                    (csr_op == 2'd2) ? (csr_rdata & ~csr_wdata) : csr_wdata;

  assign wr_en = csr_req && !csr_illegal && !trap_take;

  assign trap_target = (mtvec_q[0] && trap_cause[31])
                     ? {mtvec_q[31:1], 1'b0} + {trap_cause[29:0], 2'b00}
                     : {mtvec_q[31:1], 1'b0};
  assign mret_pc = mepc_q;
  assign priv    = priv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q     <= PRIV_M;
      mstatus_q  <= '0;
      mie_q      <= '0;
      mtvec_q    <= '0;
      mscratch_q <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
      cycle_q    <= '0;
    end else begin
      if (wr_en && (csr_addr == 12'hB00 || csr_addr == 12'hB02))
        cycle_q <= combined;
      else
        cycle_q <= cycle_q + 32'd1;

      if (wr_en) begin
        case (csr_addr)
          12'h304: mie_q      <= combined;
          12'h305: mtvec_q    <= combined & 32'hFFFF_FFFD;
          12'h340: mscratch_q <= combined;
          12'h341: mepc_q     <= combined & 32'hFFFF_FFFE;
          12'h342: mcause_q   <= combined & 32'h8000_00FF;
          default: ;
        endcase
      end

      if (trap_take) begin
        priv_q             <= PRIV_M;
        mstatus_q[12:11]   <= priv_q;
        mstatus_q[3]       <= 1'b0;
        if (mstatus_q[3]) mstatus_q[7] <= 1'b1;
        mcause_q           <= trap_cause;
        mepc_q             <= trap_epc;
      end else if (mret_take) begin
        priv_q       <= mstatus_q[12:11];
        mstatus_q[7] <= 1'b0;
        if (mstatus_q[7]) mstatus_q[3] <= 1'b1;
      end else if (wr_en && csr_addr == 12'h300) begin
        mstatus_q <= combined;
      end
    end
  end
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_req,
  input logic        csr_illegal,
  input logic        trap_take,
  input logic [31:0] trap_epc,
  input logic        mret_take,
  input logic [31:0] mret_pc,
  input logic [1:0]  priv,
  input logic [31:0] mstatus,
  input logic [31:0] mtvec
);
  p_trap_to_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> priv == 2'd3);

  p_trap_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> mret_pc == $past(trap_epc));

  p_mret_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_take && !trap_take) |=> priv == $past(mstatus[12:11]));

  p_mret_mpie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_take && !trap_take) |=> !mstatus[7]);

  p_illegal_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_illegal && !trap_take && !mret_take) |=> ($stable(mstatus) && $stable(mtvec)));
endmodule

bind mcsr_unit mcsr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_illegal(csr_illegal),
  .trap_take(trap_take), .trap_epc(trap_epc), .mret_take(mret_take),
  .mret_pc(mret_pc), .priv(priv), .mstatus(mstatus_q), .mtvec(mtvec_q)
);

// File: tb/mcsr_unit_tb.sv
module mcsr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = 12'h300;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        trap_take = 1'b0;
  logic [31:0] trap_cause = '0;
  logic [31:0] trap_epc = '0;
  logic [31:0] trap_target;
  logic        mret_take = 1'b0;
  logic [31:0] mret_pc;
  logic [1:0]  priv;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcsr_unit dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    csr_req = 1'b0; csr_op = 2'd0; csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic csr_do(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_req = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'd0;
  endtask

  task automatic do_trap(input logic [31:0] c, input logic [31:0] e);
    @(negedge clk);
    trap_take = 1'b1; trap_cause = c; trap_epc = e;
    @(negedge clk);
    trap_take = 1'b0;
  endtask

  task automatic do_mret();
    @(negedge clk);
    mret_take = 1'b1;
    @(negedge clk);
    mret_take = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R8 priv", {30'd0, priv}, 32'd3);
    peek(12'h300, v); check("R8 status", v, 0);
    peek(12'h305, v); check("R8 vector", v, 0);
    peek(12'h341, v); check("R8 saved pc", v, 0);
    peek(12'h342, v); check("R8 cause", v, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    peek(12'h301, v); check("R2 isa", v, 32'h4010_1105);
    csr_do(2'd0, 12'h301, 32'h0);
    peek(12'h301, v); check("R2 isa write ignored", v, 32'h4010_1105);
    check("R2 isa write legal", {31'd0, csr_illegal}, 0);
    peek(12'hF14, v); check("R2 hart id", v, 0);
    csr_do(2'd0, 12'h343, 32'hFFFF_FFFF);
    peek(12'h343, v); check("R2 trap value", v, 0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    csr_do(2'd0, 12'h305, 32'h0000_1003);
    peek(12'h305, v); check("R3 vector bit1", v, 32'h0000_1001);
    csr_do(2'd0, 12'h341, 32'h0000_1235);
    peek(12'h341, v); check("R3 saved pc bit0", v, 32'h0000_1234);
    csr_do(2'd0, 12'h342, 32'hFFFF_FFFF);
    peek(12'h342, v); check("R3 cause mask", v, 32'h8000_00FF);
  endtask

  task automatic t_setclear();
    logic [31:0] v;
    csr_do(2'd0, 12'h340, 32'h0000_F0F0);
    csr_do(2'd1, 12'h340, 32'h0000_000F);
    peek(12'h340, v); check("R9 set", v, 32'h0000_F0FF);
    csr_do(2'd2, 12'h340, 32'h0000_00F0);
    peek(12'h340, v); check("R9 clear", v, 32'h0000_F00F);
    csr_do(2'd1, 12'h341, 32'h0000_0001);
    peek(12'h341, v); check("R9 set then mask", v, 32'h0000_1234);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    csr_do(2'd0, 12'hB00, 32'd100);
    peek(12'hB00, v); check("R4 load", v, 32'd100);
    repeat (5) @(negedge clk);
    peek(12'hB00, v); check("R4 increment", v, 32'd105);
    peek(12'hB02, v); check("R4 alias read", v, 32'd105);
    csr_do(2'd0, 12'hB02, 32'd7);
    peek(12'hB00, v); check("R4 alias write", v, 32'd7);
  endtask

  task automatic t_vector();
    trap_cause = 32'h8000_0007; #1;
    check("R6 vectored irq", trap_target, 32'h0000_101C);
    trap_cause = 32'h0000_0002; #1;
    check("R6 exception base", trap_target, 32'h0000_1000);
    csr_do(2'd0, 12'h305, 32'h0000_2000);
    trap_cause = 32'h8000_0007; #1;
    check("R6 direct mode", trap_target, 32'h0000_2000);
  endtask

  task automatic t_trap_mret();
    logic [31:0] v;
    csr_do(2'd0, 12'h300, 32'h0000_0008);
    do_trap(32'h8000_000B, 32'h0000_0400);
    check("R5 priv", {30'd0, priv}, 3);
    peek(12'h300, v); check("R5 status stack", v, 32'h0000_1880);
    peek(12'h341, v); check("R5 saved pc", v, 32'h0000_0400);
    peek(12'h342, v); check("R5 cause", v, 32'h8000_000B);
    check("R7 return pc", mret_pc, 32'h0000_0400);
    do_mret();
    peek(12'h300, v); check("R7 status unstack", v, 32'h0000_1808);
    check("R7 priv", {30'd0, priv}, 3);
  endtask

  task automatic t_user();
    logic [31:0] v;
    peek(12'h7C0, v); check("R1 unimplemented", {31'd0, csr_illegal}, 1);
    csr_addr = 12'h340; csr_op = 2'd3; #1;
    check("R1 op 3", {31'd0, csr_illegal}, 1);
    csr_op = 2'd0;
    csr_do(2'd0, 12'h300, 32'h0);
    do_mret();
    check("R7 drop to user", {30'd0, priv}, 0);
    peek(12'h300, v); check("R1 user status access", {31'd0, csr_illegal}, 1);
    csr_do(2'd0, 12'h340, 32'hDEAD_BEEF);
    csr_do(2'd0, 12'h305, 32'h0000_3000);
    do_trap(32'h0000_0008, 32'h0000_0200);
    check("R5 trap from user priv", {30'd0, priv}, 3);
    peek(12'h300, v); check("R5 previous priv user", v, 32'h0);
    peek(12'h340, v); check("R1 illegal write dropped", v, 32'h0000_F00F);
    peek(12'h305, v); check("R1 illegal vector write dropped", v, 32'h0000_2000);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    csr_req = 1'b1; csr_op = 2'd0; csr_addr = 12'h341; csr_wdata = 32'h0000_5554;
    trap_take = 1'b1; trap_cause = 32'h3; trap_epc = 32'h0000_0600;
    @(negedge clk);
    csr_req = 1'b0; trap_take = 1'b0;
    peek(12'h341, v); check("R10 trap wins saved pc", v, 32'h0000_0600);
    @(negedge clk);
    csr_req = 1'b1; csr_addr = 12'h340; csr_wdata = 32'h1111_1111;
    trap_take = 1'b1; trap_cause = 32'h5; trap_epc = 32'h0000_0700;
    @(negedge clk);
    csr_req = 1'b0; trap_take = 1'b0;
    peek(12'h340, v); check("R10 write dropped", v, 32'h0000_F00F);
    peek(12'h342, v); check("R10 cause", v, 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readonly();
    t_masks();
    t_setclear();
    t_counter();
    t_vector();
    t_trap_mret();
    t_user();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule